// File: doc/BRIEF.md
# Pixel Coincidence and Multiplicity Trigger

This block turns one bunch-clock sample of per-chip hit flags from two detector layers into fast trigger decisions. The inner layer supplies `N_IN` flags and the outer layer `N_OUT` flags. A flag is set when at least one pixel on that chip was hit.

A table of `N_PAIR` entries defines the coincidences of interest. Each entry names one inner chip and one outer chip and has an enable bit. An entry "fires" when it is enabled and both of its named chips are hit. The table is built offline from the detector geometry, so that every pair lines up with the interaction region.

From each sample the block derives five results, all registered once, one cycle after the sample:
- a global OR of every chip flag;
- a vertex flag, set when any entry fires;
- the number of entries that fire;
- a multiplicity flag that compares the number of hit chips with a threshold;
- a high-count flag that compares the number of firing entries with a second threshold.

The pair table and both thresholds are loaded while the run input is low. Writes are refused while the block is running. All outputs stay at zero while the run input is low.

Top module: `trk_coinc_trigger`

## Requirements
- R1: In reset, every output is 0, every table entry is disabled, and both thresholds are set to all ones (127 for 7-bit thresholds). So after reset, with no configuration, the multiplicity flag and the high-count flag stay 0 even when every chip is hit.
- R2: An entry fires only when its enable bit is 1, the inner flag at its inner index is 1, and the outer flag at its outer index is 1. A disabled entry never fires.
- R3: `o_vtx` is 1 exactly when at least one entry fires.
- R4: `o_trk_cnt` equals the number of entries that fire. Two entries holding the same pair are counted separately.
- R5: `o_gor` is the OR of all `N_IN + N_OUT` chip flags.
- R6: `o_mult` is 1 when the number of set flags (inner plus outer) is greater than or equal to the chip threshold.
- R7: `o_trk_hi` is 1 when `o_trk_cnt` is greater than or equal to the pair-count threshold.
- R8: Each output reflects the flags, table and thresholds as they stand at one rising edge, and appears at the output just after that edge (one register stage).
- R9: At any rising edge where `run` is 0, all five outputs become 0.
- R10: Table and threshold writes take effect only at an edge where `run` is 0. Writes at an edge where `run` is 1 are ignored.
- R11: An entry whose inner index is `N_IN` or more, or whose outer index is `N_OUT` or more, never fires.
- R12: A table write is selected by `cfg_pair_addr` and stores `cfg_pair_en`, `cfg_pair_in` and `cfg_pair_out` together. A threshold write stores both `cfg_chip_thr` and `cfg_trk_thr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | 1 = process samples; 0 = configure, outputs held at 0 |
| fo_inner | input | N_IN (40) | Inner-layer chip hit flags |
| fo_outer | input | N_OUT (80) | Outer-layer chip hit flags |
| cfg_pair_we | input | 1 | Table write strobe |
| cfg_pair_addr | input | 6 | Table entry to write |
| cfg_pair_en | input | 1 | Enable bit for the entry |
| cfg_pair_in | input | 6 | Inner chip index of the entry |
| cfg_pair_out | input | 7 | Outer chip index of the entry |
| cfg_thr_we | input | 1 | Threshold write strobe |
| cfg_chip_thr | input | 7 | Hit-chip threshold for `o_mult` |
| cfg_trk_thr | input | 7 | Pair-count threshold for `o_trk_hi` |
| o_gor | output | 1 | Global OR |
| o_vtx | output | 1 | At least one entry fired |
| o_trk_cnt | output | 7 | Number of entries fired |
| o_mult | output | 1 | Hit-chip count at or above threshold |
| o_trk_hi | output | 1 | Pair count at or above threshold |

## Verification
The pair count and the chip multiplicity are computed from the same sample and land on the same edge. Directed patterns are chosen to sit exactly on each threshold and one step below it, so a stage that is off by one shows up as a mismatch in that single cycle.

A table or threshold write is placed on the last idle edge before `run` rises. The very first active result must then use the new entry. The reverse case is also provoked: writes while running, including a threshold of zero, must leave every later result unchanged.

A behavioural model predicts all five outputs on every cycle.

// File: rtl/trk_pkg.sv
package trk_pkg;
  localparam int DEF_N_IN   = 40;
  localparam int DEF_N_OUT  = 80;
  localparam int DEF_N_PAIR = 64;

  typedef struct packed {
    logic gor;
    logic vtx;
    logic mult;
    logic hi;
  } trk_flags_t;
endpackage

// File: rtl/trk_popcount.sv
module trk_popcount #(
  parameter int W     = 8,
  parameter int OUT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec,
  output logic [OUT_W-1:0] cnt
);
  // Loop form; synthesis balances it into an adder tree.
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) cnt = cnt + OUT_W'(vec[i]);
  end
endmodule

// File: rtl/trk_pair_table.sv
module trk_pair_table #(
  parameter int N_PAIR = 64,
  parameter int PA_W   = 6,
  parameter int II_W   = 6,
  parameter int OI_W   = 7
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           run,
  input  logic                           we,
  input  logic [PA_W-1:0]                addr,
  input  logic                           en_in,
  input  logic [II_W-1:0]                in_idx,
  input  logic [OI_W-1:0]                out_idx,
  output logic [N_PAIR-1:0]              pair_en,
  output logic [N_PAIR-1:0][II_W-1:0]    pair_in,
  output logic [N_PAIR-1:0][OI_W-1:0]    pair_out
);
  logic wr_ok;
  assign wr_ok = we && !run && (int'(addr) < N_PAIR);

  always_ff @(posedge clk) begin
    if (rst) pair_en <= '0;
    else if (wr_ok) pair_en[addr] <= en_in;
  end

  // Index storage carries no reset; only the enable bits do.
  always_ff @(posedge clk) begin
    if (wr_ok) begin
      pair_in[addr]  <= in_idx;
      pair_out[addr] <= out_idx;
    end
  end

  // R10: contents frozen while running
  p_locked_r10: assert property (@(posedge clk) disable iff (rst)
    run |=> $stable(pair_en));
  // R1: a reset edge leaves every entry disabled
  p_rst_clear_r1: assert property (@(posedge clk)
    rst |=> (pair_en == '0));
endmodule

// File: rtl/trk_coinc_array.sv
module trk_coinc_array #(
  parameter int N_IN   = 40,
  parameter int N_OUT  = 80,
  parameter int N_PAIR = 64,
  parameter int II_W   = 6,
  parameter int OI_W   = 7
) (
  input  logic [N_IN-1:0]                fo_inner,
  input  logic [N_OUT-1:0]               fo_outer,
  input  logic [N_PAIR-1:0]              pair_en,
  input  logic [N_PAIR-1:0][II_W-1:0]    pair_in,
  input  logic [N_PAIR-1:0][OI_W-1:0]    pair_out,
  output logic [N_PAIR-1:0]              trk
);
  localparam int IN_SPAN  = 1 << II_W;
  localparam int OUT_SPAN = 1 << OI_W;

  // Zero-extended copies: out-of-range indices read a 0 (R11).
  logic [IN_SPAN-1:0]  in_ext;
  logic [OUT_SPAN-1:0] out_ext;
  assign in_ext  = IN_SPAN'(fo_inner);
  assign out_ext = OUT_SPAN'(fo_outer);

  for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
    assign trk[p] = pair_en[p] & in_ext[pair_in[p]] & out_ext[pair_out[p]];
  end
endmodule

// File: rtl/trk_coinc_trigger.sv
module trk_coinc_trigger
  import trk_pkg::*;
#(
  parameter int N_IN   = DEF_N_IN,
  parameter int N_OUT  = DEF_N_OUT,
  parameter int N_PAIR = DEF_N_PAIR,
  localparam int PA_W   = $clog2(N_PAIR),
  localparam int II_W   = $clog2(N_IN),
  localparam int OI_W   = $clog2(N_OUT),
  localparam int CNT_W  = $clog2(N_PAIR + 1),
  localparam int CHIP_W = $clog2(N_IN + N_OUT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [N_IN-1:0]   fo_inner,
  input  logic [N_OUT-1:0]  fo_outer,
  input  logic              cfg_pair_we,
  input  logic [PA_W-1:0]   cfg_pair_addr,
  input  logic              cfg_pair_en,
  input  logic [II_W-1:0]   cfg_pair_in,
  input  logic [OI_W-1:0]   cfg_pair_out,
  input  logic              cfg_thr_we,
  input  logic [CHIP_W-1:0] cfg_chip_thr,
  input  logic [CNT_W-1:0]  cfg_trk_thr,
  output logic              o_gor,
  output logic              o_vtx,
  output logic [CNT_W-1:0]  o_trk_cnt,
  output logic              o_mult,
  output logic              o_trk_hi
);
  localparam int CI_W = $clog2(N_IN + 1);
  localparam int CO_W = $clog2(N_OUT + 1);

  logic [N_PAIR-1:0]           pair_en;
  logic [N_PAIR-1:0][II_W-1:0] pair_in;
  logic [N_PAIR-1:0][OI_W-1:0] pair_out;
  logic [N_PAIR-1:0]           trk;
  logic [CNT_W-1:0]            trk_cnt;
  logic [CI_W-1:0]             cnt_in;
  logic [CO_W-1:0]             cnt_out;
  logic [CHIP_W-1:0]           chip_cnt;
  logic [CHIP_W-1:0]           chip_thr_q;
  logic [CNT_W-1:0]            trk_thr_q;
  trk_flags_t                  flags_q;
  logic [CNT_W-1:0]            cnt_q;

  trk_pair_table #(.N_PAIR(N_PAIR), .PA_W(PA_W), .II_W(II_W), .OI_W(OI_W)) u_table (
    .clk(clk), .rst(rst), .run(run), .we(cfg_pair_we), .addr(cfg_pair_addr),
    .en_in(cfg_pair_en), .in_idx(cfg_pair_in), .out_idx(cfg_pair_out),
    .pair_en(pair_en), .pair_in(pair_in), .pair_out(pair_out));

  trk_coinc_array #(.N_IN(N_IN), .N_OUT(N_OUT), .N_PAIR(N_PAIR),
                    .II_W(II_W), .OI_W(OI_W)) u_coinc (
    .fo_inner(fo_inner), .fo_outer(fo_outer), .pair_en(pair_en),
    .pair_in(pair_in), .pair_out(pair_out), .trk(trk));

  trk_popcount #(.W(N_PAIR), .OUT_W(CNT_W)) u_cnt_trk (.vec(trk), .cnt(trk_cnt));
  trk_popcount #(.W(N_IN),   .OUT_W(CI_W))  u_cnt_in  (.vec(fo_inner), .cnt(cnt_in));
  trk_popcount #(.W(N_OUT),  .OUT_W(CO_W))  u_cnt_out (.vec(fo_outer), .cnt(cnt_out));

  assign chip_cnt = CHIP_W'(cnt_in) + CHIP_W'(cnt_out);

  // Thresholds: reset to all ones, written only while idle.
  always_ff @(posedge clk) begin
    if (rst) begin
      chip_thr_q <= '1;
      trk_thr_q  <= '1;
    end else if (cfg_thr_we && !run) begin
      chip_thr_q <= cfg_chip_thr;
      trk_thr_q  <= cfg_trk_thr;
    end
  end

  // Single result stage: count, flags and comparisons on the same edge.
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      flags_q <= '0;
      cnt_q   <= '0;
    end else begin
      flags_q.gor  <= (|fo_inner) | (|fo_outer);
      flags_q.vtx  <= |trk;
      flags_q.mult <= (chip_cnt >= chip_thr_q);
      flags_q.hi   <= (trk_cnt >= trk_thr_q);
      cnt_q        <= trk_cnt;
    end
  end

  assign o_gor     = flags_q.gor;
  assign o_vtx     = flags_q.vtx;
  assign o_mult    = flags_q.mult;
  assign o_trk_hi  = flags_q.hi;
  assign o_trk_cnt = cnt_q;

  // R9: idle edge clears every result
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !run |=> (o_trk_cnt == '0 && !o_vtx && !o_gor && !o_mult && !o_trk_hi));
  // R3: presence flag agrees with the count
  p_vtx_cnt_r3: assert property (@(posedge clk) disable iff (rst)
    o_vtx == (o_trk_cnt != '0));
  // R4: count never exceeds the table size
  p_cnt_range_r4: assert property (@(posedge clk) disable iff (rst)
    int'(o_trk_cnt) <= N_PAIR);
  // R5: a coincidence implies at least one hit chip
  p_vtx_gor_r5: assert property (@(posedge clk) disable iff (rst)
    o_vtx |-> o_gor);
  // R7: high-count flag consistent with count and threshold
  p_hi_thr_r7: assert property (@(posedge clk) disable iff (rst)
    o_trk_hi |-> (o_trk_cnt >= trk_thr_q));
  // R10: thresholds frozen while running
  p_thr_locked_r10: assert property (@(posedge clk) disable iff (rst)
    run |=> ($stable(chip_thr_q) && $stable(trk_thr_q)));
endmodule

// File: tb/trk_coinc_trigger_test.sv
module trk_coinc_trigger_test;
  localparam int NI = 40;
  localparam int NO = 80;
  localparam int NP = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          run = 1'b0;
  logic [NI-1:0] fo_inner = '0;
  logic [NO-1:0] fo_outer = '0;
  logic          cfg_pair_we = 1'b0;
  logic [5:0]    cfg_pair_addr = '0;
  logic          cfg_pair_en = 1'b0;
  logic [5:0]    cfg_pair_in = '0;
  logic [6:0]    cfg_pair_out = '0;
  logic          cfg_thr_we = 1'b0;
  logic [6:0]    cfg_chip_thr = '0;
  logic [6:0]    cfg_trk_thr = '0;
  logic          o_gor, o_vtx, o_mult, o_trk_hi;
  logic [6:0]    o_trk_cnt;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  string phase = "";

  // reference model state
  bit m_en [NP];
  int m_in [NP];
  int m_out[NP];
  int m_cthr, m_tthr;
  int e_cnt;
  bit e_gor, e_vtx, e_mult, e_hi;

  always #4 clk = ~clk;

  trk_coinc_trigger uut (
    .clk(clk), .rst(rst), .run(run), .fo_inner(fo_inner), .fo_outer(fo_outer),
    .cfg_pair_we(cfg_pair_we), .cfg_pair_addr(cfg_pair_addr), .cfg_pair_en(cfg_pair_en),
    .cfg_pair_in(cfg_pair_in), .cfg_pair_out(cfg_pair_out), .cfg_thr_we(cfg_thr_we),
    .cfg_chip_thr(cfg_chip_thr), .cfg_trk_thr(cfg_trk_thr),
    .o_gor(o_gor), .o_vtx(o_vtx), .o_trk_cnt(o_trk_cnt), .o_mult(o_mult), .o_trk_hi(o_trk_hi));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", req, phase, act, exp);
    end
  endtask

  // R8: predict from values present at the coming edge, then sample after it.
  task automatic tick();
    e_cnt = 0; e_gor = 0; e_vtx = 0; e_mult = 0; e_hi = 0;
    if (!rst && run) begin
      for (int p = 0; p < NP; p++)
        if (m_en[p] && m_in[p] < NI && m_out[p] < NO)          // R2, R11
          if (fo_inner[m_in[p]] && fo_outer[m_out[p]]) e_cnt++;
      e_gor  = (fo_inner != '0) || (fo_outer != '0);
      e_vtx  = e_cnt > 0;
      e_mult = ($countones(fo_inner) + $countones(fo_outer)) >= m_cthr;
      e_hi   = e_cnt >= m_tthr;
    end
    if (rst) begin
      for (int p = 0; p < NP; p++) m_en[p] = 0;
      m_cthr = 127; m_tthr = 127;
    end else if (!run) begin                                     // R10, R12
      if (cfg_pair_we) begin
        m_en[cfg_pair_addr]  = cfg_pair_en;
        m_in[cfg_pair_addr]  = cfg_pair_in;
        m_out[cfg_pair_addr] = cfg_pair_out;
      end
      if (cfg_thr_we) begin
        m_cthr = cfg_chip_thr; m_tthr = cfg_trk_thr;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk("R4", o_trk_cnt, e_cnt);
    chk("R3", o_vtx, e_vtx);
    chk("R5", o_gor, e_gor);
    chk("R6", o_mult, e_mult);
    chk("R7", o_trk_hi, e_hi);
  endtask

  task automatic wr_pair(int a, bit en, int ii, int oi);
    cfg_pair_we = 1; cfg_pair_addr = 6'(a); cfg_pair_en = en;
    cfg_pair_in = 6'(ii); cfg_pair_out = 7'(oi);
    tick();
    cfg_pair_we = 0;
  endtask

  task automatic wr_thr(int c, int t);
    cfg_thr_we = 1; cfg_chip_thr = 7'(c); cfg_trk_thr = 7'(t);
    tick();
    cfg_thr_we = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    phase = "R1 reset";
    fo_inner = '1; fo_outer = '1; run = 1;
    repeat (3) tick();
    rst = 0;
    phase = "R1 unconfigured run, all hit";
    repeat (2) tick();

    phase = "R12 R9 configure";
    run = 0; fo_inner = '0; fo_outer = '0;
    for (int p = 0; p < 50; p++) wr_pair(p, 1, p % NI, (2 * p) % NO);
    wr_pair(50, 1, 45, 3);         // R11 inner index out of range
    wr_pair(51, 1, 3, 100);        // R11 outer index out of range
    wr_pair(53, 0, 7, 14);         // R2 disabled entry
    wr_thr(30, 10);
    wr_pair(52, 1, 0, 0);          // duplicate of entry 0, on last idle edge

    phase = "R4 R8 first active sample uses last write";
    run = 1;
    fo_inner = 40'h1; fo_outer = 80'h1;
    tick();
    phase = "R5 zero pattern";
    fo_inner = '0; fo_outer = '0;
    tick();
    phase = "R11 out-of-range indices";
    fo_inner = '1; fo_outer = '0; fo_outer[3] = 1; fo_outer[100 - 64] = 0;
    tick();
    phase = "R6 all hit";
    fo_inner = '1; fo_outer = '1;
    tick();
    phase = "R6 chip threshold exact";
    fo_inner = '0; fo_outer = '0; fo_inner[29:0] = '1;
    tick();
    phase = "R6 chip threshold minus one";
    fo_inner[29] = 0;
    tick();
    phase = "R7 pair threshold exact";
    fo_inner = '0; fo_outer = '0;
    for (int i = 1; i <= 5; i++) begin fo_inner[i] = 1; fo_outer[2 * i] = 1; end
    tick();
    phase = "R7 pair threshold below";
    fo_outer[10] = 0;
    tick();

    phase = "R10 writes while running";
    cfg_thr_we = 1; cfg_chip_thr = 0; cfg_trk_thr = 0;
    cfg_pair_we = 1; cfg_pair_addr = 6'd53; cfg_pair_en = 1;
    cfg_pair_in = 6'd7; cfg_pair_out = 7'd14;
    fo_inner = '0; fo_outer = '0; fo_inner[7] = 1; fo_outer[14] = 1;
    tick();
    cfg_thr_we = 0; cfg_pair_we = 0;
    fo_inner = 40'h1; fo_outer = '0;
    tick();

    phase = "R2 random traffic";
    for (int n = 0; n < 400; n++) begin
      fo_inner = {$urandom, $urandom};
      fo_outer = {$urandom, $urandom, $urandom};
      if (n % 3 == 0) fo_inner = fo_inner & {$urandom, $urandom};
      run = (n % 37) != 36;      // R9 occasional idle edge
      if (!run) begin phase = "R9 idle with hits"; end
      else phase = "R2 random traffic";
      tick();
    end

    phase = "R9 drop run";
    run = 0; fo_inner = '1; fo_outer = '1;
    tick();
    tick();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule